// File: doc/BRIEF.md
# Packed decimal to binary codec

This block moves a signed integer between two forms. The first is a ten-byte packed-decimal operand: nine bytes carry eighteen decimal digits, two to a byte, and the top byte carries the sign. The second is a 64-bit two's-complement word. The direction is picked with each start request. A decode reads the operand from a byte-array input and accumulates one byte per cycle. An encode writes the operand to a byte-array output and takes one decimal digit pair per division step. A serial divide-by-100 engine produces the digit pairs.

The engine has a single-cycle `start` request and a `done` pulse. It is busy from the cycle after an accepted start until the cycle `done` rises. While the engine is busy, any start request is dropped. Each result output keeps its value until the next operation of its own kind overwrites it. During a decode, `dec_in` must be held steady. During an encode, `bin_in` is captured in the start cycle and may change afterwards.

Top module: `pbcd_codec`

## Requirements
- R1: Decode processes byte 8 first and byte 0 last. At each step it forms value = value*100 + high_nibble*10 + low_nibble, where the high nibble (bits 7:4) is the tens digit and byte 0 holds the least significant pair. Nibbles above 9 are not rejected; they are used with their binary weight.
- R2: Decode negates the accumulated magnitude (two's complement) when bit 7 of byte 9 is 1. Bits 6:0 of byte 9 have no effect, so a negative zero decodes to 0.
- R3: A decode raises `done` exactly 9 cycles after the clock edge that accepts the start, with `bin_out` valid in that cycle. A decode leaves `dec_out` and `ovf` unchanged.
- R4: An encode writes byte 9 of `dec_out` as 0x80 for a negative input and 0x00 otherwise. It then works on the magnitude, including the magnitude 2^63 of the most negative input.
- R5: An encode fills bytes 0 upward with successive remainders modulo 100. Each byte is packed as tens in bits 7:4 and units in bits 3:0. The quotient replaces the value after each byte.
- R6: Once the value reaches zero, every remaining byte up to byte 8 is written as 0x00, one byte per cycle. A pair taken by division costs BIN_W+1 cycles. With n pairs taken by division, `done` rises BIN_W*n+9 cycles after the accepting edge.
- R7: An encode sets `ovf` when the magnitude is 10^18 or more and clears it otherwise. On overflow, bytes 0 to 8 hold only the low 18 digits. `ovf` keeps its value until the next encode.
- R8: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R9: A start request while `busy` is high is ignored, whatever the direction and data inputs show. Changing `bin_in` after an encode is accepted does not change its result.
- R10: After reset, `busy`, `done` and `ovf` are 0, and `bin_out` and `dec_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; sampled when idle |
| pack_mode | input | 1 | 0 = decimal to binary, 1 = binary to decimal |
| dec_in | input | 10x8 | Packed-decimal operand, byte 9 carries the sign |
| bin_in | input | 64 | Two's-complement operand for encode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Last encode had a magnitude of 10^18 or more |
| bin_out | output | 64 | Result of the last decode |
| dec_out | output | 10x8 | Result of the last encode |

## Verification
A decode finishes a fixed 9 cycles after its accepting edge. An encode finishes BIN_W*n+9 cycles after it, where n is the number of digit pairs the model takes by division before the value reaches zero (at most 9). The bench computes that latency for every operation. It samples on the falling edge after each rising edge and expects `busy` to be high until that cycle and `done` to be high in that cycle only. In the done cycle it compares `bin_out`, `dec_out` and `ovf` against its own model of all three outputs. This also shows that the other direction's result was left untouched.

// File: rtl/pbcd_pkg.sv
package pbcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNPACK = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_ZFILL  = 2'd3
    } pbcd_state_e;

    localparam int unsigned PAIR_RADIX = 100;

endpackage

// File: rtl/pbcd_pair_codec.sv
module pbcd_pair_codec (
    input  logic [7:0] byte_in,
    output logic [7:0] pair_val,
    input  logic [6:0] rem_in,
    output logic [7:0] byte_out
);
    logic [14:0] scaled;
    logic [3:0]  tens;
    logic [3:0]  units;

    always_comb begin
        // high nibble times ten plus low nibble, no digit range check
        pair_val = ({4'd0, byte_in[7:4]} << 3) + ({4'd0, byte_in[7:4]} << 1)
                 + {4'd0, byte_in[3:0]};
        // divide by ten via reciprocal multiply, exact for 0..99
        scaled   = {8'd0, rem_in} * 15'd205;
        tens     = 4'(scaled >> 11);
        units    = rem_in[3:0] - {tens[0], 3'b000} - {tens[2:0], 1'b0};
        byte_out = {tens, units};
    end
endmodule

// File: rtl/pbcd_div_serial.sv
module pbcd_div_serial #(
    parameter int W       = 64,
    parameter int DIVISOR = 100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic [W-1:0]                 dividend,
    output logic [W-1:0]                 quot,
    output logic [$clog2(DIVISOR)-1:0]   rem,
    output logic                         ready
);
    localparam int RW = $clog2(DIVISOR);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [RW-1:0] rem;
        logic [W-1:0]  quo;
    } div_regs_t;

    div_regs_t     r_d, r_q;
    logic [RW:0]   shifted;
    logic          fits;

    always_comb begin
        r_d     = r_q;
        shifted = {r_q.rem, r_q.quo[W-1]};
        fits    = (shifted >= (RW+1)'(DIVISOR));
        if (go) begin
            r_d.run = 1'b1;
            r_d.cnt = CW'(W);
            r_d.rem = '0;
            r_d.quo = dividend;
        end else if (r_q.run && r_q.cnt != '0) begin
            r_d.rem = fits ? RW'(shifted - (RW+1)'(DIVISOR)) : RW'(shifted);
            r_d.quo = {r_q.quo[W-2:0], fits};
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quot  = r_q.quo;
    assign rem   = r_q.rem;
    assign ready = r_q.run && (r_q.cnt == '0);

    // R5: partial remainder never reaches the divisor
    a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run |-> (r_q.rem < RW'(DIVISOR)));

    // R6: each division step retires one dividend bit per cycle
    a_r6_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.run && r_q.cnt != '0 && !go) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
endmodule

// File: rtl/pbcd_codec.sv
module pbcd_codec
    import pbcd_pkg::*;
#(
    parameter int NBYTES = 10,
    parameter int BIN_W  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     pack_mode,
    input  logic [NBYTES-1:0][7:0]   dec_in,
    input  logic [BIN_W-1:0]         bin_in,
    output logic                     busy,
    output logic                     done,
    output logic                     ovf,
    output logic [BIN_W-1:0]         bin_out,
    output logic [NBYTES-1:0][7:0]   dec_out
);
    localparam int NPAIRS    = NBYTES - 1;
    localparam int SIGN_BYTE = NBYTES - 1;
    localparam int IDX_W     = $clog2(NBYTES);
    localparam int RW        = $clog2(PAIR_RADIX);
    localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(NPAIRS - 1);

    function automatic logic [BIN_W-1:0] radix_power(input int n);
        logic [BIN_W-1:0] p;
        p = BIN_W'(1);
        for (int i = 0; i < n; i++) p = p * BIN_W'(PAIR_RADIX);
        return p;
    endfunction

    localparam logic [BIN_W-1:0] DEC_LIMIT = radix_power(NPAIRS);

    typedef struct packed {
        pbcd_state_e              state;
        logic [IDX_W-1:0]         idx;
        logic [BIN_W-1:0]         acc;
        logic                     done;
        logic                     ovf;
        logic [BIN_W-1:0]         bin;
        logic [NBYTES-1:0][7:0]   dec;
    } codec_regs_t;

    codec_regs_t        r_d, r_q;
    logic [7:0]         cur_byte;
    logic [7:0]         pair_val;
    logic [7:0]         pack_byte;
    logic               div_go;
    logic [BIN_W-1:0]   div_arg;
    logic [BIN_W-1:0]   div_quot;
    logic [RW-1:0]      div_rem;
    logic               div_ready;
    logic [BIN_W-1:0]   mag;
    logic [BIN_W-1:0]   acc_step;

    assign cur_byte = dec_in[r_q.idx];

    pbcd_pair_codec u_pair (
        .byte_in  (cur_byte),
        .pair_val (pair_val),
        .rem_in   (div_rem),
        .byte_out (pack_byte)
    );

    pbcd_div_serial #(
        .W       (BIN_W),
        .DIVISOR (PAIR_RADIX)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_arg),
        .quot     (div_quot),
        .rem      (div_rem),
        .ready    (div_ready)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_go   = 1'b0;
        div_arg  = r_q.acc;
        mag      = bin_in[BIN_W-1] ? (~bin_in + BIN_W'(1)) : bin_in;
        acc_step = r_q.acc * BIN_W'(PAIR_RADIX) + BIN_W'(pair_val);

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (!pack_mode) begin
                        r_d.state = ST_UNPACK;
                        r_d.idx   = LAST_PAIR;
                        r_d.acc   = '0;
                    end else begin
                        r_d.ovf            = (mag >= DEC_LIMIT);
                        r_d.dec[SIGN_BYTE] = bin_in[BIN_W-1] ? 8'h80 : 8'h00;
                        r_d.idx            = '0;
                        r_d.acc            = mag;
                        if (mag != '0) begin
                            div_go    = 1'b1;
                            div_arg   = mag;
                            r_d.state = ST_DIVIDE;
                        end else begin
                            r_d.state = ST_ZFILL;
                        end
                    end
                end
            end
            ST_UNPACK: begin
                r_d.acc = acc_step;
                if (r_q.idx == '0) begin
                    r_d.bin   = dec_in[SIGN_BYTE][7] ? (~acc_step + BIN_W'(1)) : acc_step;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx - 1'b1;
                end
            end
            ST_DIVIDE: begin
                if (div_ready) begin
                    r_d.dec[r_q.idx] = pack_byte;
                    r_d.acc          = div_quot;
                    if (r_q.idx == LAST_PAIR) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        if (div_quot != '0) begin
                            div_go  = 1'b1;
                            div_arg = div_quot;
                        end else begin
                            r_d.state = ST_ZFILL;
                        end
                    end
                end
            end
            ST_ZFILL: begin
                r_d.dec[r_q.idx] = 8'h00;
                if (r_q.idx == LAST_PAIR) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign ovf     = r_q.ovf;
    assign bin_out = r_q.bin;
    assign dec_out = r_q.dec;

    // R8: completion pulse lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: engine is idle whenever done is shown
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1: decode walks bytes downward one per cycle
    a_r1_index_walks_down: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_UNPACK && r_q.idx != '0)
        |=> (r_q.state == ST_UNPACK && r_q.idx == $past(r_q.idx) - 1'b1));

    // R9: a decode in flight cannot be turned into an encode
    a_r9_decode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_UNPACK) |=> (r_q.state == ST_UNPACK || r_q.state == ST_IDLE));

    // R6: zero filling never resumes division
    a_r6_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ZFILL) |=> (r_q.state == ST_ZFILL || r_q.state == ST_IDLE));

    // R5: packed pairs contain decimal digits only
    a_r5_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DIVIDE && div_ready)
        |-> (pack_byte[7:4] <= 4'd9 && pack_byte[3:0] <= 4'd9));

    // R4: sign byte during an encode is one of the two legal codes
    a_r4_sign_code: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DIVIDE || r_q.state == ST_ZFILL)
        |-> (dec_out[SIGN_BYTE] == 8'h80 || dec_out[SIGN_BYTE] == 8'h00));

    // R7: overflow flag only moves when an encode is accepted
    a_r7_ovf_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ovf));
endmodule

// File: tb/pbcd_codec_tb.sv
`timescale 1ns/100ps
module pbcd_codec_tb;
    localparam int NB = 10;
    localparam int BW = 64;
    localparam int NP = NB - 1;
    localparam logic [BW-1:0] LIMIT = 64'd1000000000000000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pack_mode = 1'b0;
    logic [NB-1:0][7:0] dec_in = '0;
    logic [BW-1:0] bin_in = '0;
    logic busy, done, ovf;
    logic [BW-1:0] bin_out;
    logic [NB-1:0][7:0] dec_out;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [BW-1:0]      mdl_bin = '0;
    logic [NB-1:0][7:0] mdl_dec = '0;
    logic               mdl_ovf = 1'b0;

    always #2.5 clk = ~clk;

    pbcd_codec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pack_mode(pack_mode),
        .dec_in(dec_in), .bin_in(bin_in), .busy(busy), .done(done),
        .ovf(ovf), .bin_out(bin_out), .dec_out(dec_out)
    );

    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [NB-1:0][7:0] enc(logic [BW-1:0] mag, bit neg, output int npairs);
        logic [BW-1:0] v;
        logic [BW-1:0] r;
        logic [NB-1:0][7:0] b;
        v = mag;
        npairs = 0;
        for (int i = 0; i < NP; i++) begin
            if (v != 0) begin
                r = v % 100;
                b[i] = {4'(r / 10), 4'(r % 10)};
                v = v / 100;
                npairs++;
            end else begin
                b[i] = 8'h00;
            end
        end
        b[NB-1] = neg ? 8'h80 : 8'h00;
        return b;
    endfunction

    function automatic logic [BW-1:0] dec_value(logic [NB-1:0][7:0] b);
        logic [BW-1:0] v;
        v = '0;
        for (int i = NP - 1; i >= 0; i--)
            v = v * 100 + BW'(b[i][7:4]) * 10 + BW'(b[i][3:0]);
        if (b[NB-1][7]) v = -v;
        return v;
    endfunction

    task automatic run_op(bit mode, logic [NB-1:0][7:0] din, logic [BW-1:0] bin,
                          bit meddle, string req);
        int lat;
        int np;
        logic [BW-1:0] mag;
        string tim;
        if (mode) begin
            mag     = bin[BW-1] ? -bin : bin;
            mdl_dec = enc(mag, bin[BW-1], np);
            mdl_ovf = (mag >= LIMIT);
            lat     = BW * np + NP;
            tim     = "R6/R8";
        end else begin
            mdl_bin = dec_value(din);
            lat     = NP;
            tim     = "R3/R8";
        end
        @(negedge clk);
        pack_mode = mode;
        dec_in    = din;
        bin_in    = bin;
        start     = 1'b1;
        for (int c = 0; c <= lat + 1; c++) begin
            @(negedge clk);
            if (c == 0) start = 1'b0;
            chk(tim, "busy", busy, c < lat);
            chk(tim, "done", done, c == lat);
            if (c == lat) begin
                chk(req, "bin_out", bin_out, mdl_bin);
                chk(req, "dec_out", dec_out, mdl_dec);
                chk(req, "ovf", ovf, mdl_ovf);
            end
            if (meddle && c == 3) begin
                start     = 1'b1;
                pack_mode = ~mode;
                bin_in    = ~bin;
            end
            if (meddle && c == 4) start = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int np;
        logic [NB-1:0][7:0] v;
        repeat (3) @(negedge clk);
        // R10: state during and after reset
        chk("R10", "busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy", busy, 0);
        chk("R10", "done", done, 0);
        chk("R10", "ovf", ovf, 0);
        chk("R10", "bin_out", bin_out, 0);
        chk("R10", "dec_out", dec_out, 0);

        // R1: positive decode, byte order and digit weights
        run_op(1'b0, enc(64'd123456789012345678, 1'b0, np), '0, 1'b0, "R1");
        // R2: negative decode
        run_op(1'b0, enc(64'd987654321, 1'b1, np), '0, 1'b0, "R2");
        // R1 and R2: nibbles above nine, sign byte low bits ignored
        v = '1;
        v[NB-1] = 8'h7F;
        run_op(1'b0, v, '0, 1'b0, "R1");
        // R2: negative zero
        v = '0;
        v[NB-1] = 8'h80;
        run_op(1'b0, v, '0, 1'b0, "R2");
        // R9: start during decode is dropped
        run_op(1'b0, enc(64'd999999999999999999, 1'b1, np), '0, 1'b1, "R9");

        // R6: zero encodes by filling only
        run_op(1'b1, '0, 64'd0, 1'b0, "R6");
        // R5: one pair then fill
        run_op(1'b1, '0, 64'd5, 1'b0, "R5");
        // R4: negative input gives sign code
        run_op(1'b1, '0, -64'd1234, 1'b0, "R4");
        // R5: largest value without overflow
        run_op(1'b1, '0, 64'd999999999999999999, 1'b0, "R5");
        // R7: exactly the limit overflows, low digits all zero
        run_op(1'b1, '0, LIMIT, 1'b0, "R7");
        // R4: most negative input, magnitude 2^63
        run_op(1'b1, '0, 64'h8000_0000_0000_0000, 1'b0, "R4");
        // R7: flag cleared by next in-range encode
        run_op(1'b1, '0, 64'd42, 1'b0, "R7");
        // R9: start and new bin_in during encode have no effect
        run_op(1'b1, '0, -64'd7, 1'b1, "R9");
        // R7: largest positive input
        run_op(1'b1, '0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R7");
        // R3: decode leaves encode results alone
        run_op(1'b0, enc(64'd31415926, 1'b0, np), '0, 1'b0, "R3");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule